// File: doc/BRIEF.md
# PLL Coefficient Search Engine

This unit picks the reference divider M, the feedback multiplier N and the post-divider code PL for a clock synthesiser. It takes a requested output rate and a reference rate, both in kHz. It then walks the post-divider codes, the reference dividers and the few feedback values around each ideal ratio, and keeps the legal triple whose rounded output lies nearest to the request. The VCO window and the comparison-frequency window limit which triples count. The walk stops early on an exact hit.

Every quotient comes from one shared restoring divider that yields one quotient bit per cycle. The control sequencer moves one step each time a division completes. When the walk ends, the unit computes the rate the chosen triple really gives, pulses done, and holds the triple, the remaining error, the achieved rate and a no-match flag until the next start.

Top module: `pll_coef_search`

## Requirements
- R1: After reset, busy, done and no_match are all low.
- R2: A start pulse seen while busy is low captures req_khz and ref_khz and raises busy on the next cycle. A start seen while busy is high is ignored, and so is any change of the inputs during a search.
- R3: Post-divider code c selects the divider 1,2,3,4,5,6,8,10,12,16,12,16,20,24,32 for c = 0..14, and divider 1 for c = 15. The table is not monotonic.
- R4: Let T = 2*req_khz and V = T + floor(T/50). The highest code searched comes from ceil(C/V), where C = max(2,064,000, V). The lowest code comes from floor(1,000,000/V). Each value is clamped to 1..32 and then mapped to the lowest code whose divider is at least that value, or to code 14 if no code qualifies. Codes are visited in rising order.
- R5: For each code, M runs upward from 1. The comparison frequency ref/M (integer) ends the M walk when it falls below 12,000. M is skipped when that frequency is above 38,000.
- R6: N goes from floor(T*div*M/ref) to its ceiling. If the floor is above 255, the M walk for that code ends. N below 8 is skipped. A candidate counts only when floor(ref*N/M) lies within [1,000,000, C].
- R7: A candidate's error is |floor((vco + floor(div/2))/div) - T|. Only a strictly smaller error replaces the kept triple, and an error of zero ends the search at once.
- R8: When no candidate counts, no_match is high, and the result is M = 255, N = 8, PL = 1 with err_khz all ones. Otherwise no_match is low.
- R9: rate_khz = floor(floor(ref*N / (M*div)) / 2) for the returned triple.
- R10: done is high for exactly one cycle, with busy low. The results are valid from that cycle and stay unchanged until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a search (taken only while busy is low) |
| req_khz | input | RATE_W | Requested output rate, kHz |
| ref_khz | input | RATE_W | Reference rate, kHz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| pll_m | output | MW | Chosen reference divider |
| pll_n | output | NW | Chosen feedback multiplier |
| pll_pl | output | 4 | Chosen post-divider code |
| err_khz | output | RATE_W | Error of the chosen triple against 2*req |
| no_match | output | 1 | No legal candidate was found |
| rate_khz | output | RATE_W | Rate achieved by the chosen triple |

## Verification
The search takes a data-dependent number of cycles, about fifty per division. So no result is due at a fixed offset from start. The only promise is that busy rises one cycle after an accepted start, and the bench checks that directly. For everything else the bench polls done at the falling edge and compares the triple, error, flag and rate in the same cycle that done is seen. Five cycles later it compares them again to confirm they are held. The expected values were worked out by hand from the requirements and cover an exact hit, a best-effort result with residual error, a request above the VCO ceiling, the highest code, and a reference too slow for any M.

// File: rtl/pcs_pkg.sv
// Shared definitions for the PLL coefficient search engine.
// Holds the post-divider code table, its inverse lookup and the
// sequencer state type. Assumes codes are 4 bits and dividers 6 bits.
package pcs_pkg;

    localparam int PL_W    = 4;
    localparam int DIV_W   = 6;
    localparam int PL_LAST = 14;

    // Map a post-divider code to its divide ratio; unused codes divide by 1.
    function automatic logic [DIV_W-1:0] pl_to_div(input logic [PL_W-1:0] code);
        logic [DIV_W-1:0] d;
        case (code)
            4'd0:    d = 6'd1;
            4'd1:    d = 6'd2;
            4'd2:    d = 6'd3;
            4'd3:    d = 6'd4;
            4'd4:    d = 6'd5;
            4'd5:    d = 6'd6;
            4'd6:    d = 6'd8;
            4'd7:    d = 6'd10;
            4'd8:    d = 6'd12;
            4'd9:    d = 6'd16;
            4'd10:   d = 6'd12;
            4'd11:   d = 6'd16;
            4'd12:   d = 6'd20;
            4'd13:   d = 6'd24;
            4'd14:   d = 6'd32;
            default: d = 6'd1;
        endcase
        return d;
    endfunction

    // Lowest code whose divider reaches the wanted ratio; falls back to the last code.
    function automatic logic [PL_W-1:0] div_to_pl(input logic [DIV_W-1:0] want);
        logic [PL_W-1:0] code;
        logic            hit;
        code = PL_W'(PL_LAST);
        hit  = 1'b0;
        for (int c = 0; c < PL_LAST; c++) begin
            if (!hit && (pl_to_div(PL_W'(c)) >= want)) begin
                code = PL_W'(c);
                hit  = 1'b1;
            end
        end
        return code;
    endfunction

    typedef enum logic [3:0] {
        S_IDLE, S_VT0, S_BHI, S_BLO, S_PLINIT, S_U, S_N, S_NLOOP,
        S_VCO, S_LWV, S_MNEXT, S_PLNEXT, S_RATE, S_DONE
    } pcs_state_e;

endpackage

// File: rtl/pcs_divider.sv
// Restoring unsigned divider, one quotient bit per cycle.
// A go pulse latches both operands; valid pulses once with quotient and
// remainder W cycles later. Assumes the caller never issues go while a
// division runs and never divides by zero.
module pcs_divider #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         valid,
    output logic [W-1:0] quot,
    output logic [W-1:0] rem
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  quo_q, rem_q, dsr_q, dvd_q;
    logic [CW-1:0] cnt_q;
    logic          run_q, val_q;
    logic [W:0]    trial;
    logic          fits;

    // Trial subtraction on the shifted partial remainder.
    always_comb begin
        trial = {rem_q, quo_q[W-1]};
        fits  = (trial >= {1'b0, dsr_q});
    end

    // Iterate one bit per cycle and flag completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo_q <= '0;
            rem_q <= '0;
            dsr_q <= '0;
            dvd_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            val_q <= 1'b0;
        end else if (go) begin
            quo_q <= dividend;
            dvd_q <= dividend;
            rem_q <= '0;
            dsr_q <= divisor;
            cnt_q <= CW'(W);
            run_q <= 1'b1;
            val_q <= 1'b0;
        end else if (run_q) begin
            rem_q <= fits ? W'(trial - {1'b0, dsr_q}) : trial[W-1:0];
            quo_q <= {quo_q[W-2:0], fits};
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) begin
                run_q <= 1'b0;
                val_q <= 1'b1;
            end
        end else begin
            val_q <= 1'b0;
        end
    end

    assign valid = val_q;
    assign quot  = quo_q;
    assign rem   = rem_q;

    // R9: every finished division reconstructs its dividend exactly.
    a_r9_div_identity: assert property (@(posedge clk) disable iff (!rst_n)
        (val_q && dsr_q != '0) |-> ((2*W)'(quo_q) * (2*W)'(dsr_q) + (2*W)'(rem_q) == (2*W)'(dvd_q)
                                    && rem_q < dsr_q));
endmodule

// File: rtl/pcs_cand_check.sv
// Candidate qualification for the coefficient search.
// Checks a VCO value against its window and scores a rounded output
// against the target, saturating the error to EW bits.
module pcs_cand_check #(
    parameter int DW = 48,
    parameter int EW = 32
) (
    input  logic [DW-1:0] vco_in,
    input  logic [DW-1:0] vco_lo,
    input  logic [DW-1:0] vco_hi,
    input  logic [DW-1:0] out_in,
    input  logic [DW-1:0] target,
    input  logic [EW-1:0] best_err,
    output logic          in_range,
    output logic [EW-1:0] err,
    output logic          better,
    output logic          exact
);
    logic [DW-1:0] diff;

    // Window test, absolute error and improvement decision.
    always_comb begin
        in_range = (vco_in >= vco_lo) && (vco_in <= vco_hi);
        diff     = (out_in >= target) ? (out_in - target) : (target - out_in);
        err      = (diff > DW'({EW{1'b1}})) ? {EW{1'b1}} : diff[EW-1:0];
        better   = (err < best_err);
        exact    = (diff == '0);
    end
endmodule

// File: rtl/pll_coef_search.sv
// PLL coefficient search engine (top).
// Sequences the nested code / M / N walk over one shared divider and
// keeps the closest legal triple. Assumes req_khz and ref_khz are
// nonzero; inputs are captured only at an accepted start.
module pll_coef_search
    import pcs_pkg::*;
#(
    parameter int RATE_W     = 32,
    parameter int DW         = 48,
    parameter int M_MIN      = 1,
    parameter int M_MAX      = 255,
    parameter int N_MIN      = 8,
    parameter int N_MAX      = 255,
    parameter int U_MIN      = 12000,
    parameter int U_MAX      = 38000,
    parameter int VCO_MIN    = 1000000,
    parameter int VCO_MAX    = 2064000,
    parameter int DIV_LO     = 1,
    parameter int DIV_HI     = 32,
    parameter int DEF_PL     = 1,
    parameter int VT_MARGIN  = 50,
    localparam int MW        = $clog2(M_MAX + 1),
    localparam int NW        = $clog2(N_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [RATE_W-1:0] req_khz,
    input  logic [RATE_W-1:0] ref_khz,
    output logic              busy,
    output logic              done,
    output logic [MW-1:0]     pll_m,
    output logic [NW-1:0]     pll_n,
    output logic [PL_W-1:0]   pll_pl,
    output logic [RATE_W-1:0] err_khz,
    output logic              no_match,
    output logic [RATE_W-1:0] rate_khz
);
    pcs_state_e          st;
    logic                pend;
    logic [DW-1:0]       ref_q, tgt_q, vt0_q, vceil_q, vt_q, u_q, vco_q;
    logic [PL_W-1:0]     pl_q, pl_hi_q, bpl;
    logic [MW-1:0]       m_q, bm;
    logic [NW:0]         n_q, n2_q;
    logic [NW-1:0]       bn;
    logic [RATE_W-1:0]   berr, rate_q;
    logic                nm_q;

    logic                div_go, dv, is_div;
    logic [DW-1:0]       dvd, dsr, dq, dr;
    logic [DW-1:0]       vt0_nx, vceil_nx;
    logic [DIV_W-1:0]    cur_div, clamp_q;
    logic [PL_W-1:0]     code_q;
    logic                c_in, c_better, c_exact, upd;
    logic [RATE_W-1:0]   c_err;

    // Current divider, clamped quotient and its code, derived VCO limits.
    always_comb begin
        cur_div  = pl_to_div(pl_q);
        if (dq < DW'(DIV_LO))      clamp_q = DIV_W'(DIV_LO);
        else if (dq > DW'(DIV_HI)) clamp_q = DIV_W'(DIV_HI);
        else                       clamp_q = dq[DIV_W-1:0];
        code_q   = div_to_pl(clamp_q);
        vt0_nx   = tgt_q + dq;
        vceil_nx = (vt0_nx > DW'(VCO_MAX)) ? vt0_nx : DW'(VCO_MAX);
    end

    // Operand selection for the shared divider, by sequencer state.
    always_comb begin
        is_div = 1'b1;
        dvd    = '0;
        dsr    = DW'(1);
        case (st)
            S_VT0:  begin dvd = tgt_q;                       dsr = DW'(VT_MARGIN); end
            S_BHI:  begin dvd = vceil_q + vt0_q - DW'(1);    dsr = vt0_q; end
            S_BLO:  begin dvd = DW'(VCO_MIN);                dsr = vt0_q; end
            S_U:    begin dvd = ref_q;                       dsr = DW'(m_q); end
            S_N:    begin dvd = DW'(vt_q * DW'(m_q));        dsr = ref_q; end
            S_VCO:  begin dvd = DW'(ref_q * DW'(n_q));       dsr = DW'(m_q); end
            S_LWV:  begin dvd = vco_q + DW'(cur_div >> 1);   dsr = DW'(cur_div); end
            S_RATE: begin dvd = DW'(ref_q * DW'(bn));
                          dsr = DW'(DW'(bm) * DW'(pl_to_div(bpl))); end
            default: is_div = 1'b0;
        endcase
        div_go = is_div && !pend;
    end

    pcs_divider #(.W(DW)) u_div (
        .clk(clk), .rst_n(rst_n), .go(div_go), .dividend(dvd), .divisor(dsr),
        .valid(dv), .quot(dq), .rem(dr)
    );

    pcs_cand_check #(.DW(DW), .EW(RATE_W)) u_cand (
        .vco_in(dq), .vco_lo(DW'(VCO_MIN)), .vco_hi(vceil_q), .out_in(dq),
        .target(tgt_q), .best_err(berr), .in_range(c_in), .err(c_err),
        .better(c_better), .exact(c_exact)
    );

    assign upd = (st == S_LWV) && pend && dv && c_better;

    // Search sequencer: one step per division result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE; pend <= 1'b0;
            ref_q <= '0; tgt_q <= '0; vt0_q <= '0; vceil_q <= '0; vt_q <= '0;
            u_q <= '0; vco_q <= '0; pl_q <= '0; pl_hi_q <= '0; m_q <= '0;
            n_q <= '0; n2_q <= '0;
            bm <= MW'(M_MAX); bn <= NW'(N_MIN); bpl <= PL_W'(DEF_PL);
            berr <= '1; rate_q <= '0; nm_q <= 1'b0;
        end else begin
            if (div_go) pend <= 1'b1;
            if (pend && dv) pend <= 1'b0;
            case (st)
                S_IDLE, S_DONE: begin
                    st <= S_IDLE;
                    if (start) begin
                        ref_q <= DW'(ref_khz);
                        tgt_q <= DW'(req_khz) << 1;
                        bm <= MW'(M_MAX); bn <= NW'(N_MIN); bpl <= PL_W'(DEF_PL);
                        berr <= '1; nm_q <= 1'b0;
                        st <= S_VT0;
                    end
                end
                S_VT0: if (pend && dv) begin
                    vt0_q <= vt0_nx; vceil_q <= vceil_nx; st <= S_BHI;
                end
                S_BHI: if (pend && dv) begin
                    pl_hi_q <= code_q; st <= S_BLO;
                end
                S_BLO: if (pend && dv) begin
                    pl_q <= code_q;
                    st   <= (code_q > pl_hi_q) ? S_RATE : S_PLINIT;
                end
                S_PLINIT: begin
                    vt_q <= DW'(tgt_q * DW'(cur_div));
                    m_q  <= MW'(M_MIN);
                    st   <= S_U;
                end
                S_U: if (pend && dv) begin
                    u_q <= dq;
                    if (dq < DW'(U_MIN))      st <= S_PLNEXT;
                    else if (dq > DW'(U_MAX)) st <= S_MNEXT;
                    else                      st <= S_N;
                end
                S_N: if (pend && dv) begin
                    if (dq > DW'(N_MAX)) st <= S_PLNEXT;
                    else begin
                        n_q  <= dq[NW:0];
                        n2_q <= dq[NW:0] + (NW+1)'(dr != '0);
                        st   <= S_NLOOP;
                    end
                end
                S_NLOOP: begin
                    if (n_q > n2_q)                 st  <= S_MNEXT;
                    else if (n_q < (NW+1)'(N_MIN))  n_q <= n_q + 1'b1;
                    else if (n_q > (NW+1)'(N_MAX))  st  <= S_MNEXT;
                    else                            st  <= S_VCO;
                end
                S_VCO: if (pend && dv) begin
                    vco_q <= dq;
                    if (c_in) st <= S_LWV;
                    else begin n_q <= n_q + 1'b1; st <= S_NLOOP; end
                end
                S_LWV: if (pend && dv) begin
                    if (c_better) begin
                        bm <= m_q; bn <= n_q[NW-1:0]; bpl <= pl_q; berr <= c_err;
                    end
                    if (c_exact) st <= S_RATE;
                    else begin n_q <= n_q + 1'b1; st <= S_NLOOP; end
                end
                S_MNEXT: begin
                    if (m_q == MW'(M_MAX)) st <= S_PLNEXT;
                    else begin m_q <= m_q + 1'b1; st <= S_U; end
                end
                S_PLNEXT: begin
                    if (pl_q >= pl_hi_q) st <= S_RATE;
                    else begin pl_q <= pl_q + 1'b1; st <= S_PLINIT; end
                end
                S_RATE: if (pend && dv) begin
                    rate_q <= RATE_W'(dq >> 1);
                    nm_q   <= (berr == '1);
                    st     <= S_DONE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign busy     = (st != S_IDLE) && (st != S_DONE);
    assign done     = (st == S_DONE);
    assign pll_m    = bm;
    assign pll_n    = bn;
    assign pll_pl   = bpl;
    assign err_khz  = berr;
    assign no_match = nm_q;
    assign rate_khz = rate_q;

    // R2: an accepted start raises busy on the next cycle.
    a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    // R10: done lasts one cycle and never overlaps busy.
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R10: results hold while idle and no start arrives.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable({pll_m, pll_n, pll_pl, err_khz, no_match, rate_khz}));
    // R8: a miss reports the default triple.
    a_r8_default_triple: assert property (@(posedge clk) disable iff (!rst_n)
        (done && no_match) |-> (pll_m == MW'(M_MAX) && pll_n == NW'(N_MIN) && pll_pl == PL_W'(DEF_PL)));
    // R5: an accepted candidate had its comparison frequency in the window.
    a_r5_window: assert property (@(posedge clk) disable iff (!rst_n)
        upd |-> (u_q >= DW'(U_MIN) && u_q <= DW'(U_MAX)));
    // R6: an accepted candidate had a legal VCO and N.
    a_r6_vco_window: assert property (@(posedge clk) disable iff (!rst_n)
        upd |-> (vco_q >= DW'(VCO_MIN) && vco_q <= vceil_q
                 && n_q >= (NW+1)'(N_MIN) && n_q <= (NW+1)'(N_MAX)));
    // R7: every replacement strictly lowers the kept error.
    a_r7_err_drops: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> (err_khz < $past(err_khz)));
endmodule

// File: tb/pll_coef_search_bench.sv
// Self-checking bench: vector table walk, then reset, hold and busy-start cases.
module pll_coef_search_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] req_khz = '0;
    logic [31:0] ref_khz = '0;
    logic        busy, done, no_match;
    logic [7:0]  pll_m, pll_n;
    logic [3:0]  pll_pl;
    logic [31:0] err_khz, rate_khz;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    pll_coef_search u_pll_coef_search (
        .clk(clk), .rst_n(rst_n), .start(start), .req_khz(req_khz), .ref_khz(ref_khz),
        .busy(busy), .done(done), .pll_m(pll_m), .pll_n(pll_n), .pll_pl(pll_pl),
        .err_khz(err_khz), .no_match(no_match), .rate_khz(rate_khz)
    );

    typedef struct packed {
        logic [31:0] req;
        logic [31:0] rf;
        logic [7:0]  m;
        logic [7:0]  n;
        logic [3:0]  pl;
        logic [31:0] err;
        logic        nm;
        logic [31:0] rate;
    } vec_t;

    // Hand-derived expectations:
    // 0: code range 5..9, exact hit at code 6 (R4)
    // 1: ref 12000, only M=1, code 4 gives 1600 then code 5 exact (R6, R7)
    // 2: request above VCO ceiling raises it; M=2 then M=3 improves (R5, R7)
    // 3: highest code 14 (divider 32), code 13 rejected by VCO floor (R3)
    // 4: ref too slow for any M: defaults returned (R8)
    localparam vec_t VECS [5] = '{
        '{32'd72000,   32'd38400, 8'd2,   8'd60,  4'd6,  32'd0,          1'b0, 32'd72000},
        '{32'd100000,  32'd12000, 8'd1,   8'd100, 4'd5,  32'd0,          1'b0, 32'd100000},
        '{32'd1100000, 32'd38400, 8'd3,   8'd172, 4'd0,  32'd1600,       1'b0, 32'd1100800},
        '{32'd20000,   32'd38400, 8'd3,   8'd100, 4'd14, 32'd0,          1'b0, 32'd20000},
        '{32'd50000,   32'd10000, 8'd255, 8'd8,   4'd1,  32'hFFFFFFFF,   1'b1, 32'd78}
    };
    localparam string TAGS [5] = '{"R4", "R6", "R5", "R3", "R8"};

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic kick(input logic [31:0] rq, input logic [31:0] rf);
        @(negedge clk);
        req_khz = rq;
        ref_khz = rf;
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
    endtask

    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 30000 && !seen; i++) begin
            if (done) seen = 1'b1;
            else @(negedge clk);
        end
    endtask

    task automatic check_vec(input vec_t v, input string tag);
        check(tag, "pll_m",  32'(pll_m),  32'(v.m));
        check(tag, "pll_n",  32'(pll_n),  32'(v.n));
        check(tag, "pll_pl", 32'(pll_pl), 32'(v.pl));
        check("R7", "err_khz", err_khz, v.err);
        check("R8", "no_match", 32'(no_match), 32'(v.nm));
        check("R9", "rate_khz", rate_khz, v.rate);
    endtask

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R10 watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        bit seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "busy", 32'(busy), 32'd0);
        check("R1", "done", 32'(done), 32'd0);
        check("R1", "no_match", 32'(no_match), 32'd0);

        // Table walk
        for (int k = 0; k < 5; k++) begin
            kick(VECS[k].req, VECS[k].rf);
            check("R2", "busy after start", 32'(busy), 32'd1);
            wait_done(seen);
            check("R10", "done seen", 32'(seen), 32'd1);
            check("R10", "busy at done", 32'(busy), 32'd0);
            check_vec(VECS[k], TAGS[k]);
            @(negedge clk);
            check("R10", "done one cycle", 32'(done), 32'd0);
        end

        // R10: results held several cycles after done
        repeat (5) @(negedge clk);
        check_vec(VECS[4], "R10");

        // R2: start and input changes during a search are ignored
        kick(VECS[0].req, VECS[0].rf);
        repeat (30) @(negedge clk);
        req_khz = VECS[1].req;
        ref_khz = VECS[1].rf;
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        wait_done(seen);
        check("R2", "done seen", 32'(seen), 32'd1);
        check_vec(VECS[0], "R2");
        @(negedge clk);
        check("R2", "no restart", 32'(busy), 32'd0);

        // R1: reset mid-search clears busy
        kick(VECS[2].req, VECS[2].rf);
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "busy after reset", 32'(busy), 32'd0);
        check("R1", "done after reset", 32'(done), 32'd0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule